// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives host software one 32-bit register through which it reads or writes a 16-bit management register inside an attached Ethernet PHY. Software writes the register to issue a command. The bridge then runs one complete serial management frame on the MDC/MDIO pins. When the frame ends, it reports completion through the top bit of the same register. The PHY address is fixed by a parameter, 1 by default.

The direction of the completion flag depends on the command. A write command is issued with the flag set, and hardware clears the flag when the frame ends. A read command is issued with the flag clear, and hardware sets the flag once the returned data is in the low half-word. The host interface is a plain control pulse with no back-pressure. A write that lands while a frame is running is dropped, so software has to poll the flag before it issues the next command.

MDC comes from the system clock through a divider that is set at elaboration. The divider keeps MDC at or below the management-clock limit. At 50 MHz with a 2.5 MHz limit, one frame of 64 bits takes 1280 system cycles, which is far inside any polling budget.

Top module: `mdio_bridge`

## Requirements
- R1: After reset the register reads as zero at its offset, MDC is low and MDIO is not driven.
- R2: A host write at offset 0x60 with bit 31 = 1 starts a write frame. The frame is 32 ones, then 0,1, then opcode 0,1, then the 5-bit PHY address, then the register address from bits 20:16, then turnaround 1,0, then the data from bits 15:0. Every field goes out most significant bit first, and MDIO is driven for the whole frame.
- R3: A host write at offset 0x60 with bit 31 = 0 starts a read frame with opcode 1,0. MDIO is released from the first turnaround bit (frame bit 46) through the last bit (frame bit 63).
- R4: MDC has a period of 2*HALF system cycles, where HALF = ceil(CLK_HZ / (2*MDC_MAX_HZ)). Each bit holds MDC low for HALF cycles and then high for HALF cycles. The MDIO output changes only at the start of a low half.
- R5: On a read, the bridge samples MDIO in the system cycle in which MDC rises, for each of frame bits 48..63. The first sample becomes data bit 15.
- R6: A write frame ends 128*HALF cycles after it is accepted. Bit 31 then reads 0, and bits 15:0 still hold the written data.
- R7: A read frame ends 128*HALF cycles after it is accepted. Bit 31 then reads 1, and bits 15:0 hold the 16 sampled bits.
- R8: At offset 0x60 the register reads as {flag, ten zero bits, register address in 20:16, data in 15:0}. The address is captured from the command.
- R9: A host write at 0x60 that arrives while a frame is running is ignored: the register contents and the running frame do not change.
- R10: A write at any other offset starts nothing and changes nothing, and a read at any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register contents at the addressed offset |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the bridge |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value from the pin |

## Verification
If the bit counter is wrong, a field lands in the wrong place. The first misplaced MDIO level then shows on the pin within one MDC period, and the completion flag moves at the wrong cycle. If the divider phase is wrong, MDC is offset from the first cycle of the frame. If the read sampling point is skewed, data is shifted by one or more positions, which shows up only when the flag sets at the end of the read. For that reason the reply words use asymmetric bit patterns. A busy indication that is lost or stuck shows either as a second command that is taken mid-frame, with the address field changing, or as MDC staying quiet after a command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        is_rd,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] wd
  );
    mdio_op_e op;
    op = is_rd ? OP_RD : OP_WR;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regad,
            (is_rd ? 2'b11 : 2'b10), (is_rd ? 16'hFFFF : wd)};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic bit_end
);
  localparam int CW = (2 * HALF > 1) ? $clog2(2 * HALF) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
  localparam logic [CW-1:0] END_AT  = CW'(2 * HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (run) begin
      if (cnt == END_AT) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == RISE_AT) mdc <= 1'b1;
      end
    end
  end

  assign rise_evt = run && (cnt == RISE_AT);
  assign bit_end  = run && (cnt == END_AT);
endmodule

// File: rtl/mdio_frame_tx.sv
module mdio_frame_tx
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_rd_in,
  input  logic                  run,
  input  logic                  bit_end,
  output logic                  mdio_out,
  output logic                  mdio_oe,
  output logic                  last_bit,
  output logic                  in_data
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idx;
  logic                  rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      idx  <= '0;
      rd_q <= 1'b0;
    end else if (start) begin
      sh   <= frame_in;
      idx  <= '0;
      rd_q <= is_rd_in;
    end else if (bit_end) begin
      sh  <= {sh[FRAME_BITS-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  assign mdio_out = sh[FRAME_BITS-1];
  assign mdio_oe  = run && !(rd_q && (idx >= IW'(TA_FIRST)));
  assign last_bit = (idx == IW'(FRAME_BITS - 1));
  assign in_data  = (idx >= IW'(DATA_FIRST));
endmodule

// File: rtl/mdio_bridge.sv
module mdio_bridge
  import mdio_pkg::*;
#(
  parameter int           CLK_HZ     = 50_000_000,
  parameter int           MDC_MAX_HZ = 2_500_000,
  parameter logic [4:0]   PHY_ADDR   = 5'd1,
  parameter int           ADDR_W     = 8,
  parameter logic [7:0]   REG_OFFSET = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int HALF = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  logic        busy, is_rd, flag_q;
  logic [4:0]  regad;
  logic [15:0] data_q, rx_sh;
  logic        hit, accept, rise_evt, bit_end, last_bit, in_data;
  logic        unused_wdata;

  assign hit          = (host_addr == ADDR_W'(REG_OFFSET));
  assign accept       = host_wr && hit && !busy;
  assign unused_wdata = ^host_wdata[30:21];

  mdio_mdc_gen #(.HALF(HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy),
    .mdc(mdc), .rise_evt(rise_evt), .bit_end(bit_end)
  );

  mdio_frame_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .frame_in(build_frame(!host_wdata[31], PHY_ADDR, host_wdata[20:16], host_wdata[15:0])),
    .is_rd_in(!host_wdata[31]), .run(busy), .bit_end(bit_end),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .last_bit(last_bit), .in_data(in_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      is_rd  <= 1'b0;
      flag_q <= 1'b0;
      regad  <= '0;
      data_q <= '0;
      rx_sh  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      is_rd  <= !host_wdata[31];
      flag_q <= host_wdata[31];
      regad  <= host_wdata[20:16];
      data_q <= host_wdata[15:0];
    end else if (busy) begin
      if (rise_evt && is_rd && in_data) rx_sh <= {rx_sh[14:0], mdio_in};
      if (bit_end && last_bit) begin
        busy   <= 1'b0;
        flag_q <= is_rd;
        if (is_rd) data_q <= rx_sh;
      end
    end
  end

  assign host_rdata = hit ? {flag_q, 10'b0, regad, data_q} : 32'h0;
endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       busy,
  input logic       is_rd,
  input logic       flag_q,
  input logic [4:0] regad,
  input logic       mdc,
  input logic       mdio_out,
  input logic       mdio_oe
);
  // R1: nothing moves on the pins while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R4: the pin level is held through the high half of MDC
  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R9: a command during a frame leaves the address field alone
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr) |=> $stable(regad));

  // R6: a write keeps its flag set until its frame ends
  a_r6_write_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_rd && flag_q) |=> (flag_q || !busy));

  // R7: a read keeps its flag clear until its frame ends
  a_r7_read_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd) |=> (!flag_q || !busy));
endmodule

bind mdio_bridge mdio_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .busy(busy), .is_rd(is_rd),
  .flag_q(flag_q), .regad(regad), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_bridge.sv
module tb_mdio_bridge;
  localparam int H = 10;  // 50 MHz / (2 * 2.5 MHz), rounded up
  localparam int FRAME_CYC = 128 * H;

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, mdio_in = 1'b1;
  logic [7:0]  host_addr = 8'h60;
  logic [31:0] host_wdata = '0, host_rdata;
  logic mdc, mdio_out, mdio_oe;

  int tests = 0, fails = 0, cycles = 0;

  mdio_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #10 clk = ~clk;

  // behavioural reference
  bit m_busy = 0, m_isrd = 0, m_flag = 0;
  logic [4:0]  m_reg = '0;
  logic [15:0] m_data = '0, m_rx = '0, reply = '0;
  int m_t = 0;

  function automatic logic exp_bit(int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return m_isrd ? 1'b1 : 1'b0;
    if (b == 35) return m_isrd ? 1'b0 : 1'b1;
    if (b <= 40) return (5'd1 >> (40 - b)) & 1'b1;
    if (b <= 45) return m_reg[45 - b];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_data[63 - b];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        if (m_isrd && (m_t % (2*H)) == H-1 && (m_t / (2*H)) >= 48)
          m_rx = {m_rx[14:0], mdio_in};  // R5 sampling point
        m_t++;
        if (m_t == FRAME_CYC) begin
          m_busy = 0;
          m_flag = m_isrd;
          if (m_isrd) m_data = m_rx;
        end
      end else if (host_wr && host_addr == 8'h60) begin
        m_busy = 1; m_t = 0;
        m_isrd = !host_wdata[31];
        m_flag = host_wdata[31];
        m_reg  = host_wdata[20:16];
        m_data = host_wdata[15:0];
      end
    end
  end

  // PHY side: drives the reply bits during the data field of a read
  always @(negedge clk) begin
    if (m_busy && m_isrd && (m_t / (2*H)) >= 48) mdio_in <= reply[63 - m_t/(2*H)];
    else mdio_in <= 1'b1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // every-cycle comparison
  always @(negedge clk) begin
    #2;
    cycles++;
    if (rst_n) begin
      int b;
      b = m_t / (2*H);
      chk("R4 mdc", mdc, (m_busy && (m_t % (2*H)) >= H));
      if (m_isrd) begin
        chk("R3 oe", mdio_oe, (m_busy && b < 46));
        if (m_busy && b < 46) chk("R3 mdio", mdio_out, exp_bit(b));
      end else begin
        chk("R2 oe", mdio_oe, m_busy);
        if (m_busy) chk("R2 mdio", mdio_out, exp_bit(b));
      end
      if (host_addr == 8'h60) chk("R8 rdata", host_rdata, {m_flag, 10'b0, m_reg, m_data});
    end
  end

  task automatic cmd(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 8'h60;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk("R1 rdata", host_rdata, 32'h0);
    chk("R1 mdc", mdc, 1'b0);
    chk("R1 oe", mdio_oe, 1'b0);
    rst_n = 1'b1;

    // R2/R6: write reg 5
    cmd(8'h60, 32'h8005_A5C3);
    repeat (300) @(negedge clk);
    cmd(8'h60, 32'h800A_7777);  // R9: dropped while busy
    wait_done();
    #3 chk("R6 write done", host_rdata, 32'h0005_A5C3);
    chk("R9 addr kept", host_rdata[20:16], 5'd5);

    // R3/R5/R7: read reg 0x1F
    reply = 16'h1234;
    cmd(8'h60, 32'h001F_0000);
    #3 chk("R7 flag low while busy", host_rdata[31], 1'b0);
    wait_done();
    #3 chk("R7 read done", host_rdata, 32'h801F_1234);

    // R5: edge bits of the data field
    reply = 16'h8001;
    cmd(8'h60, 32'h0000_FFFF);
    wait_done();
    #3 chk("R5 msb/lsb", host_rdata, 32'h8000_8001);

    // R10: other offset
    cmd(8'h64, 32'h8003_1111);
    @(negedge clk);
    #3 chk("R10 no start mdc", {mdc, mdio_oe}, 2'b00);
    chk("R10 reg kept", host_rdata, 32'h8000_8001);
    host_addr = 8'h64;
    #1 chk("R10 other offset reads 0", host_rdata, 32'h0);
    @(negedge clk); host_addr = 8'h60;

    // back-to-back write after read, R2 with alternating data
    cmd(8'h60, 32'h8012_5A0F);
    wait_done();
    #3 chk("R6 second write", host_rdata, 32'h0012_5A0F);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule